// File: doc/BRIEF.md
# Fractional-Rate Interval Timer with Alarm

This block keeps a 56-bit free-running time count that advances at a programmable fraction of its input clock. Software sets a 16-bit numerator and a 16-bit denominator. A fractional accumulator converts their ratio into whole-unit steps of the count. When the numerator is larger than the denominator, one clock may add several units.

The count is kept as a 29-bit low word and a 27-bit high word. The high word advances by one whenever the low word wraps past its maximum. An alarm value is compared against the low word only. On a match the low word returns to zero and a sticky status bit is raised. An enable bit gates that status bit onto a registered interrupt output.

All state is reached through a simple register port. Writes take effect on the clock edge that samples them. Read data is registered and appears one cycle after the read strobe. Every register can be read and written.

Top module: `frac_interval_timer`

## Requirements
- R1: After reset the status, enable, numerator, denominator, high word and low word all read zero. The alarm reads 0x1FFFFFFF and `irq` is low.
- R2: With a non-zero denominator D and numerator N, the fractional remainder is carried between clocks. Starting from a cleared remainder, K counting edges add floor(K*N/D) units to the count, and a single edge may add more than one unit.
- R3: While the denominator register holds zero, the count does not advance.
- R4: A write to the denominator register (offset 0x9210) clears the fractional remainder. The edge of that write still counts with the old rate.
- R5: The low word wraps modulo 2^29, and each wrap adds one to the high word. The low word reads in bits 28:0 of offset 0x9410, and the high word reads in bits 31:5 of offset 0x9400.
- R6: When the low word equals the alarm (offset 0x9420, bits 28:0), the next edge loads the low word with zero instead of counting, and sets status bit 0 (offset 0x9100).
- R7: The high word never takes part in the alarm comparison, and it does not change on an alarm match.
- R8: Writing 1 to status bit 0 clears it. If an alarm match and a clear land on the same edge, the bit ends up set.
- R9: `irq` is registered and equals status bit 0 ANDed with enable bit 0 (offset 0x9140), from the same edge on which either of them changes.
- R10: The numerator is held in bits 15:0 of offset 0x9200 and the denominator in bits 15:0 of offset 0x9210. Unused bits, and addresses outside the map, read zero. Read data is valid in the cycle after `bus_rd`.
- R11: A write to either count word takes effect on the write edge. It overrides counting, the carry and the alarm reload, and counting resumes from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Alarm interrupt, status AND enable |

## Verification
The bench builds the block with its default sizes: a 16-bit rate pair, a 29-bit low word and a 27-bit high word. Because the low word can be preloaded just below 2^29, a wrap into the high word takes only a few cycles. A numerator of 0xFFFF over a denominator of 1 adds 65535 units per clock, so the bench can cross the wrap in one step and skip past an alarm value without ever equalling it. Small ratios such as 1/4 and 3/2 exercise the remainder carry, and the denominator rewrite sequence shows that the remainder is cleared.

// File: rtl/frt_pkg.sv
package frt_pkg;

  localparam int ADDR_W = 16;

  // Register byte offsets
  localparam logic [ADDR_W-1:0] OFS_STAT = 16'h9100;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 16'h9140;
  localparam logic [ADDR_W-1:0] OFS_NUM  = 16'h9200;
  localparam logic [ADDR_W-1:0] OFS_DEN  = 16'h9210;
  localparam logic [ADDR_W-1:0] OFS_HI   = 16'h9400;
  localparam logic [ADDR_W-1:0] OFS_LO   = 16'h9410;
  localparam logic [ADDR_W-1:0] OFS_ALM  = 16'h9420;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_IEN, SEL_NUM, SEL_DEN, SEL_HI, SEL_LO, SEL_ALM
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_STAT: decode_addr = SEL_STAT;
      OFS_IEN:  decode_addr = SEL_IEN;
      OFS_NUM:  decode_addr = SEL_NUM;
      OFS_DEN:  decode_addr = SEL_DEN;
      OFS_HI:   decode_addr = SEL_HI;
      OFS_LO:   decode_addr = SEL_LO;
      OFS_ALM:  decode_addr = SEL_ALM;
      default:  decode_addr = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/frt_rate_accum.sv
module frt_rate_accum #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] num,
  input  logic [RATE_W-1:0] den,
  input  logic              clr,
  output logic [RATE_W:0]   step
);

  localparam int SUM_W = RATE_W + 1;

  logic [RATE_W-1:0] acc_q;
  logic [RATE_W-1:0] rem;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  den_x;

  assign sum   = {1'b0, acc_q} + {1'b0, num};
  assign den_x = {1'b0, den};

  // Whole units available this clock, and what is left over
  always_comb begin
    if (den == '0) begin
      step = '0;
      rem  = acc_q;
    end else begin
      step = sum / den_x;
      rem  = RATE_W'(sum % den_x);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= rem;
  end

  // R2: leftover stays below the divisor used
  a_r2_rem_below_den: assert property (@(posedge clk) disable iff (rst)
    (den != '0 && !clr) |=> (acc_q < $past(den)));

  // R4: a denominator write empties the remainder
  a_r4_clr_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0));

endmodule

// File: rtl/frt_count_core.sv
module frt_count_core #(
  parameter int LO_W   = 29,
  parameter int HI_W   = 27,
  parameter int STEP_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] step,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [LO_W-1:0]   lo_wdata,
  input  logic [HI_W-1:0]   hi_wdata,
  input  logic [LO_W-1:0]   alarm,
  output logic [LO_W-1:0]   lo_q,
  output logic [HI_W-1:0]   hi_q,
  output logic              match
);

  logic [LO_W:0] lo_sum;
  logic          carry;

  assign match  = (lo_q == alarm);
  assign lo_sum = {1'b0, lo_q} + (LO_W+1)'(step);
  assign carry  = !lo_we && !match && lo_sum[LO_W];

  always_ff @(posedge clk) begin
    if (rst)        lo_q <= '0;
    else if (lo_we) lo_q <= lo_wdata;
    else if (match) lo_q <= '0;
    else            lo_q <= lo_sum[LO_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        hi_q <= '0;
    else if (hi_we) hi_q <= hi_wdata;
    else if (carry) hi_q <= hi_q + HI_W'(1);
  end

  // R6: a match reloads the low word with zero
  a_r6_match_zeroes_lo: assert property (@(posedge clk) disable iff (rst)
    (match && !lo_we) |=> (lo_q == '0));

  // R7: the high word holds across an alarm reload
  a_r7_hi_hold_on_match: assert property (@(posedge clk) disable iff (rst)
    (match && !hi_we) |=> $stable(hi_q));

  // R5: without a write the high word moves by at most one
  a_r5_hi_single_step: assert property (@(posedge clk) disable iff (rst)
    !hi_we |=> (hi_q == $past(hi_q) || hi_q == $past(hi_q) + HI_W'(1)));

  // R11: a written value lands on the write edge
  a_r11_lo_write_lands: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> (lo_q == $past(lo_wdata)));

endmodule

// File: rtl/frt_irq_ctl.sv
module frt_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic stat_we,
  input  logic stat_bit,
  input  logic en_we,
  input  logic en_bit,
  output logic stat_q,
  output logic en_q,
  output logic irq
);

  logic stat_n;
  logic en_n;

  always_comb begin
    if (set)                      stat_n = 1'b1;
    else if (stat_we && stat_bit) stat_n = 1'b0;
    else                          stat_n = stat_q;
    en_n = en_we ? en_bit : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_n;
      en_q   <= en_n;
      irq    <= stat_n & en_n;
    end
  end

  // R8: a match beats a same-edge clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> stat_q);

  // R8: write-one clears when no match competes
  a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
    (stat_we && stat_bit && !set) |=> !stat_q);

  // R9: output tracks gated status
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_q && en_q));

endmodule

// File: rtl/frac_interval_timer.sv
module frac_interval_timer #(
  parameter int DATA_W = 32,
  parameter int RATE_W = 16,
  parameter int LO_W   = 29,
  parameter int HI_W   = 27
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [frt_pkg::ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      irq
);
  import frt_pkg::*;

  localparam int HI_LSB = DATA_W - HI_W;
  localparam int STEP_W = RATE_W + 1;

  reg_sel_e          sel;
  logic [RATE_W-1:0] num_q, den_q;
  logic [LO_W-1:0]   alm_q;
  logic [STEP_W-1:0] step;
  logic [LO_W-1:0]   lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              match;
  logic              stat_q, en_q;
  logic              we_num, we_den, we_alm, we_hi, we_lo, we_stat, we_ien;
  logic [DATA_W-1:0] rd_mux;

  assign sel     = decode_addr(bus_addr);
  assign we_stat = bus_wr && (sel == SEL_STAT);
  assign we_ien  = bus_wr && (sel == SEL_IEN);
  assign we_num  = bus_wr && (sel == SEL_NUM);
  assign we_den  = bus_wr && (sel == SEL_DEN);
  assign we_hi   = bus_wr && (sel == SEL_HI);
  assign we_lo   = bus_wr && (sel == SEL_LO);
  assign we_alm  = bus_wr && (sel == SEL_ALM);

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q <= '0;
      den_q <= '0;
      alm_q <= '1;
    end else begin
      if (we_num) num_q <= bus_wdata[RATE_W-1:0];
      if (we_den) den_q <= bus_wdata[RATE_W-1:0];
      if (we_alm) alm_q <= bus_wdata[LO_W-1:0];
    end
  end

  frt_rate_accum #(.RATE_W(RATE_W)) u_accum (
    .clk  (clk),
    .rst  (rst),
    .num  (num_q),
    .den  (den_q),
    .clr  (we_den),
    .step (step)
  );

  frt_count_core #(.LO_W(LO_W), .HI_W(HI_W), .STEP_W(STEP_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .lo_we    (we_lo),
    .hi_we    (we_hi),
    .lo_wdata (bus_wdata[LO_W-1:0]),
    .hi_wdata (bus_wdata[DATA_W-1:HI_LSB]),
    .alarm    (alm_q),
    .lo_q     (lo_q),
    .hi_q     (hi_q),
    .match    (match)
  );

  frt_irq_ctl u_irq (
    .clk      (clk),
    .rst      (rst),
    .set      (match),
    .stat_we  (we_stat),
    .stat_bit (bus_wdata[0]),
    .en_we    (we_ien),
    .en_bit   (bus_wdata[0]),
    .stat_q   (stat_q),
    .en_q     (en_q),
    .irq      (irq)
  );

  always_comb begin
    case (sel)
      SEL_STAT: rd_mux = DATA_W'(stat_q);
      SEL_IEN:  rd_mux = DATA_W'(en_q);
      SEL_NUM:  rd_mux = DATA_W'(num_q);
      SEL_DEN:  rd_mux = DATA_W'(den_q);
      SEL_HI:   rd_mux = {hi_q, {HI_LSB{1'b0}}};
      SEL_LO:   rd_mux = DATA_W'(lo_q);
      SEL_ALM:  rd_mux = DATA_W'(alm_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R3: a zero divisor freezes the low word
  a_r3_den_zero_hold: assert property (@(posedge clk) disable iff (rst)
    (den_q == '0 && !we_lo && !match) |=> (lo_q == $past(lo_q)));

  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));

endmodule

// File: tb/frac_interval_timer_tb.sv
`timescale 1ns/1ps
module frac_interval_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  frac_interval_timer u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  localparam logic [15:0] A_STAT = 16'h9100, A_IEN = 16'h9140,
                          A_NUM = 16'h9200, A_DEN = 16'h9210,
                          A_HI = 16'h9400, A_LO = 16'h9410,
                          A_ALM = 16'h9420;

  typedef struct packed {
    logic [15:0] num;
    logic [15:0] den;
    logic [15:0] k;
    logic [31:0] start;
    logic [31:0] alarm;
    logic [31:0] exp_lo;
    logic [31:0] exp_hi;
    logic        exp_stat;
  } vec_t;

  // num, den, counting edges, start low, alarm, expected low, high, status
  localparam vec_t VECS [8] = '{
    '{16'd1,    16'd1, 16'd10, 32'd0,         32'h1FFFFFFF, 32'd10,      32'h0,  1'b0},
    '{16'd1,    16'd4, 16'd10, 32'd0,         32'h1FFFFFFF, 32'd2,       32'h0,  1'b0},
    '{16'd3,    16'd2, 16'd5,  32'd0,         32'h1FFFFFFF, 32'd7,       32'h0,  1'b0},
    '{16'd1000, 16'd7, 16'd3,  32'd0,         32'h1FFFFFFF, 32'd428,     32'h0,  1'b0},
    '{16'd5,    16'd0, 16'd8,  32'd100,       32'h1FFFFFFF, 32'd100,     32'h0,  1'b0},
    '{16'd1,    16'd1, 16'd6,  32'h1FFFFFFC,  32'h10,       32'd2,       32'h20, 1'b0},
    '{16'd1,    16'd1, 16'd8,  32'd0,         32'd4,        32'd3,       32'h0,  1'b1},
    '{16'hFFFF, 16'd1, 16'd2,  32'h1FFFFF00,  32'h10,       32'h1FEFE,   32'h20, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // Called just after a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rchk(input string req, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    rchk("R1 stat", A_STAT, 32'd0);
    rchk("R1 ien",  A_IEN,  32'd0);
    rchk("R1 num",  A_NUM,  32'd0);
    rchk("R1 den",  A_DEN,  32'd0);
    rchk("R1 hi",   A_HI,   32'd0);
    rchk("R1 lo",   A_LO,   32'd0);
    rchk("R1 alarm", A_ALM, 32'h1FFFFFFF);

    // Vector walk: R2 rate, R3 zero divisor, R5 wrap, R6 alarm, R11 preload
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VECS[i];
      wr(A_DEN, 32'd0);
      wr(A_ALM, v.alarm);
      wr(A_HI, 32'd0);
      wr(A_LO, v.start);
      wr(A_STAT, 32'd1);
      wr(A_NUM, {16'd0, v.num});
      wr(A_DEN, {16'd0, v.den});
      idle(int'(v.k) - 1);
      wr(A_DEN, 32'd0);
      rchk($sformatf("R2/R3/R5/R6/R11 vec%0d lo", i), A_LO, v.exp_lo);
      rchk($sformatf("R5 vec%0d hi", i), A_HI, v.exp_hi);
      rchk($sformatf("R6 vec%0d stat", i), A_STAT, {31'b0, v.exp_stat});
    end

    // R9 gating: status set, enable clear -> no irq
    wr(A_ALM, 32'd5);
    wr(A_LO, 32'd5);
    idle(2);
    chk("R9 irq masked", {31'b0, irq}, 32'd0);
    rchk("R6 stat after match", A_STAT, 32'd1);
    wr(A_IEN, 32'd1);
    chk("R9 irq on enable", {31'b0, irq}, 32'd1);
    wr(A_STAT, 32'd1);
    chk("R9 irq after clear", {31'b0, irq}, 32'd0);

    // R8 set wins over a same-edge clear
    wr(A_LO, 32'd5);
    wr(A_STAT, 32'd1);
    rchk("R8 set wins", A_STAT, 32'd1);
    chk("R9 irq after set wins", {31'b0, irq}, 32'd1);
    wr(A_STAT, 32'd1);
    rchk("R8 w1c", A_STAT, 32'd0);
    wr(A_IEN, 32'd0);

    // R7 high word does not join the match
    wr(A_ALM, 32'd3);
    wr(A_HI, 32'd3 << 5);
    wr(A_LO, 32'h100);
    idle(3);
    rchk("R7 no match via high", A_STAT, 32'd0);
    rchk("R7 low untouched", A_LO, 32'h100);

    // R10 unused bits and unmapped addresses read zero
    wr(A_NUM, 32'hFFFFFFFF);
    rchk("R10 num field", A_NUM, 32'h0000FFFF);
    wr(A_NUM, 32'd0);
    wr(A_HI, 32'hFFFFFFFF);
    rchk("R10 hi field", A_HI, 32'hFFFFFFE0);
    wr(A_LO, 32'hFFFFFFFF);
    rchk("R10 lo field", A_LO, 32'h1FFFFFFF);
    wr(A_IEN, 32'hFFFFFFFE);
    rchk("R10 ien field", A_IEN, 32'd0);
    rchk("R10 unmapped", 16'h9300, 32'd0);

    // R4 denominator rewrite drops the remainder
    wr(A_LO, 32'h40);
    wr(A_NUM, 32'd1);
    wr(A_DEN, 32'd2);
    wr(A_NUM, 32'd0);
    wr(A_DEN, 32'd2);
    wr(A_NUM, 32'd1);
    wr(A_DEN, 32'd0);
    rchk("R4 remainder cleared", A_LO, 32'h40);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule